// File: doc/BRIEF.md
# Four-Phase Overlapped Instruction Sequencer

This block sets the timing of a small two-stage processor core. Every instruction cycle is split into four clock phases, Q1 to Q4. While one instruction executes, the next one is being fetched. In Q1 the fetch side moves the current program counter onto the program-memory address output and advances the counter. Q2 and Q3 are left open for the memory to answer. On the Q4 edge the returned word is captured into the instruction register. The program memory is a separate array from data memory, read combinationally from the fetch address.

The execute side drives one strobe per phase for the instruction held in the instruction register: decode in Q1, operand read in Q2, process in Q3 and write-back in Q4. Opcode meaning, the ALU and data storage belong to other blocks. This block only produces the timing and keeps the PC, fetch address and instruction register.

A redirect request raised in Q4 loads a new program counter. It also marks the word fetched in that cycle as invalid, so the cycle that follows runs no strobes. The first cycle after reset is a fetch-only cycle.

Top module: `insn_phase_sequencer`

## Requirements
- R1: While `rst_n` is low, all outputs take their reset values at once, without waiting for a clock edge: `phase_o`=0, `pc_o`=`fetch_addr_o`=RESET_PC, `ir_o`=0, `ex_valid_o`=0, `ex_stb_o`=0. After `rst_n` rises, the core remains in that state through two rising edges and starts running on the third.
- R2: `phase_o` encodes Q1..Q4 as 0..3. It advances by one on every running edge and wraps from 3 to 0.
- R3: On the edge taken in Q1, `fetch_addr_o` loads the current `pc_o`, and `pc_o` increments modulo 2^PC_W (all-ones wraps to zero).
- R4: `ir_o` loads `imem_data` on the edge taken in Q4 and holds its value on all other edges.
- R5: In the first instruction cycle after reset, `ex_valid_o` and every strobe stay low.
- R6: `ex_stb_o` bit 0 (decode) is high in Q1, bit 1 (operand read) in Q2, bit 2 (process) in Q3 and bit 3 (write-back) in Q4. Exactly one bit is high when `ex_valid_o` is 1, and none are high when it is 0.
- R7: In the cycle where the instruction fetched from address A executes, `fetch_addr_o` presents A+1, and that word is captured into `ir_o` at the same cycle's Q4 edge.
- R8: When `flush_req` is high on the Q4 edge, `pc_o` takes `flush_target` in place of holding its value. The following instruction cycle has `ex_valid_o`=0 and no strobes.
- R9: `flush_req` sampled on a Q1, Q2 or Q3 edge has no effect.
- R10: After a flushed cycle, the word fetched from `flush_target` executes in the next cycle with strobes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_data | input | INSTR_W | Program-memory word at `fetch_addr_o` |
| flush_req | input | 1 | Redirect request, sampled on the Q4 edge |
| flush_target | input | PC_W | New program counter for a redirect |
| phase_o | output | 2 | Current phase, 0..3 = Q1..Q4 |
| pc_o | output | PC_W | Program counter |
| fetch_addr_o | output | PC_W | Program-memory address of the fetch in progress |
| ir_o | output | INSTR_W | Instruction register |
| ex_valid_o | output | 1 | Instruction register holds an instruction to execute |
| ex_stb_o | output | 4 | One-hot execute strobes: decode, operand, process, write-back |

## Verification
The bound checker checks the following on every running cycle:
- the phase step and its wrap;
- the Q1 counter step;
- the Q4-only loading of the instruction register;
- the phase slots in which the counter must stay still;
- the one-to-one link between the strobe bit and the phase;
- the redirect landing on `flush_target` with the next cycle invalid.

Only the bench scenarios can show the following:
- the fetch-only first cycle, including after a reset in the middle of a run;
- the overlap, in which the word executing at a given time came from the address fetched one cycle earlier;
- that a request outside Q4 leaves no trace at the ports;
- that an instruction fetched from a redirect target executes one cycle later, including when the target is the all-ones address and the counter wraps to zero.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int NUM_PHASES = 4;
  localparam int PHASE_W    = 2;

  typedef enum logic [PHASE_W-1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_e;

  // strobe bit positions, one per execute phase
  localparam int STB_DECODE  = 0;
  localparam int STB_OPERAND = 1;
  localparam int STB_PROCESS = 2;
  localparam int STB_WRBACK  = 3;
endpackage

// File: rtl/seq_reset_sync.sv
module seq_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/seq_phase_gen.sv
module seq_phase_gen
  import seq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  output logic [PHASE_W-1:0]    phase,
  output logic [NUM_PHASES-1:0] ph_hot
);
  phase_e phase_q;
  phase_e phase_d;

  always_comb begin
    phase_d = phase_e'(phase_q + 2'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_Q1;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;

  for (genvar k = 0; k < NUM_PHASES; k++) begin : g_hot
    assign ph_hot[k] = (phase_q == phase_e'(k));
  end
endmodule

// File: rtl/seq_fetch_unit.sv
module seq_fetch_unit
  import seq_pkg::*;
#(
  parameter int               PC_W     = 12,
  parameter int               INSTR_W  = 14,
  parameter logic [PC_W-1:0]  RESET_PC = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PHASES-1:0] ph_hot,
  input  logic [INSTR_W-1:0]    imem_data,
  input  logic                  flush_req,
  input  logic [PC_W-1:0]       flush_target,
  output logic [PC_W-1:0]       pc,
  output logic [PC_W-1:0]       fetch_addr,
  output logic [INSTR_W-1:0]    ir,
  output logic                  ir_valid
);
  logic [PC_W-1:0]    pc_q, pc_d, fa_q, fa_d;
  logic [INSTR_W-1:0] ir_q, ir_d;
  logic               val_q, val_d;
  logic               pc_en, fa_en, ir_en;
  logic               redirect;

  // clock enables
  assign redirect = ph_hot[PH_Q4] & flush_req;
  assign pc_en    = ph_hot[PH_Q1] | redirect;
  assign fa_en    = ph_hot[PH_Q1];
  assign ir_en    = ph_hot[PH_Q4];

  // next-state values
  always_comb begin
    pc_d  = redirect ? flush_target : pc_q + PC_W'(1);
    fa_d  = pc_q;
    ir_d  = imem_data;
    val_d = ~flush_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= RESET_PC;
      fa_q  <= RESET_PC;
      ir_q  <= '0;
      val_q <= 1'b0;
    end else begin
      if (pc_en) pc_q <= pc_d;
      if (fa_en) fa_q <= fa_d;
      if (ir_en) begin
        ir_q  <= ir_d;
        val_q <= val_d;
      end
    end
  end

  assign pc         = pc_q;
  assign fetch_addr = fa_q;
  assign ir         = ir_q;
  assign ir_valid   = val_q;
endmodule

// File: rtl/seq_exec_strobe.sv
module seq_exec_strobe
  import seq_pkg::*;
(
  input  logic [NUM_PHASES-1:0] ph_hot,
  input  logic                  ir_valid,
  output logic [NUM_PHASES-1:0] stb
);
  for (genvar k = 0; k < NUM_PHASES; k++) begin : g_stb
    assign stb[k] = ir_valid & ph_hot[k];
  end
endmodule

// File: rtl/insn_phase_sequencer.sv
module insn_phase_sequencer
  import seq_pkg::*;
#(
  parameter int               PC_W     = 12,
  parameter int               INSTR_W  = 14,
  parameter logic [PC_W-1:0]  RESET_PC = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [INSTR_W-1:0]    imem_data,
  input  logic                  flush_req,
  input  logic [PC_W-1:0]       flush_target,
  output logic [1:0]            phase_o,
  output logic [PC_W-1:0]       pc_o,
  output logic [PC_W-1:0]       fetch_addr_o,
  output logic [INSTR_W-1:0]    ir_o,
  output logic                  ex_valid_o,
  output logic [3:0]            ex_stb_o
);
  logic                  rst_core_n;
  logic [NUM_PHASES-1:0] ph_hot;
  logic                  ir_valid;

  seq_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n_async(rst_n),
    .rst_n_sync (rst_core_n)
  );

  seq_phase_gen u_phase (
    .clk   (clk),
    .rst_n (rst_core_n),
    .phase (phase_o),
    .ph_hot(ph_hot)
  );

  seq_fetch_unit #(
    .PC_W    (PC_W),
    .INSTR_W (INSTR_W),
    .RESET_PC(RESET_PC)
  ) u_fetch (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .ph_hot      (ph_hot),
    .imem_data   (imem_data),
    .flush_req   (flush_req),
    .flush_target(flush_target),
    .pc          (pc_o),
    .fetch_addr  (fetch_addr_o),
    .ir          (ir_o),
    .ir_valid    (ir_valid)
  );

  seq_exec_strobe u_exec (
    .ph_hot  (ph_hot),
    .ir_valid(ir_valid),
    .stb     (ex_stb_o)
  );

  assign ex_valid_o = ir_valid;
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int PC_W    = 12,
  parameter int INSTR_W = 14
) (
  input logic               clk,
  input logic               rst_core_n,
  input logic [INSTR_W-1:0] imem_data,
  input logic               flush_req,
  input logic [PC_W-1:0]    flush_target,
  input logic [1:0]         phase_o,
  input logic [PC_W-1:0]    pc_o,
  input logic [PC_W-1:0]    fetch_addr_o,
  input logic [INSTR_W-1:0] ir_o,
  input logic               ex_valid_o,
  input logic [3:0]         ex_stb_o
);
  // R2
  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    1'b1 |=> phase_o == 2'($past(phase_o) + 2'd1));

  // R3
  assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    phase_o == 2'd0 |=> (pc_o == PC_W'($past(pc_o) + PC_W'(1))) && (fetch_addr_o == $past(pc_o)));

  // R4
  assert_ir_hold_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    phase_o != 2'd3 |=> $stable(ir_o));

  assert_ir_load_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    phase_o == 2'd3 |=> ir_o == $past(imem_data));

  // R6
  assert_strobe_count_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    ex_valid_o ? ($countones(ex_stb_o) == 1) : (ex_stb_o == 4'd0));

  assert_strobe_slot_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    ex_valid_o |-> ex_stb_o[phase_o]);

  // R8
  assert_redirect_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (phase_o == 2'd3 && flush_req) |=> (pc_o == $past(flush_target)) && !ex_valid_o);

  // R9
  assert_no_redirect_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (phase_o == 2'd1 || phase_o == 2'd2) |=> $stable(pc_o) && $stable(fetch_addr_o));

  // R5
  assert_first_idle_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(rst_core_n) |-> !ex_valid_o);
endmodule

bind insn_phase_sequencer seq_checker #(.PC_W(PC_W), .INSTR_W(INSTR_W)) u_chk (
  .clk         (clk),
  .rst_core_n  (rst_core_n),
  .imem_data   (imem_data),
  .flush_req   (flush_req),
  .flush_target(flush_target),
  .phase_o     (phase_o),
  .pc_o        (pc_o),
  .fetch_addr_o(fetch_addr_o),
  .ir_o        (ir_o),
  .ex_valid_o  (ex_valid_o),
  .ex_stb_o    (ex_stb_o)
);

// File: tb/insn_phase_sequencer_bench.sv
`timescale 1ns/1ps
module insn_phase_sequencer_bench;
  localparam int PC_W    = 12;
  localparam int INSTR_W = 14;
  localparam logic [PC_W-1:0] RST_PC = '0;

  function automatic logic [INSTR_W-1:0] mem_word(input logic [PC_W-1:0] a);
    logic [31:0] t;
    t = ({20'd0, a} * 32'h9E37) ^ 32'h15A3;
    return t[INSTR_W-1:0];
  endfunction

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               flush_req = 1'b0;
  logic [PC_W-1:0]    flush_target = '0;
  logic [INSTR_W-1:0] imem_data;
  logic [1:0]         phase_o;
  logic [PC_W-1:0]    pc_o, fetch_addr_o;
  logic [INSTR_W-1:0] ir_o;
  logic               ex_valid_o;
  logic [3:0]         ex_stb_o;

  always #5 clk = ~clk;

  assign imem_data = mem_word(fetch_addr_o);

  insn_phase_sequencer #(.PC_W(PC_W), .INSTR_W(INSTR_W), .RESET_PC(RST_PC)) u_insn_phase_sequencer (
    .clk(clk), .rst_n(rst_n), .imem_data(imem_data), .flush_req(flush_req),
    .flush_target(flush_target), .phase_o(phase_o), .pc_o(pc_o),
    .fetch_addr_o(fetch_addr_o), .ir_o(ir_o), .ex_valid_o(ex_valid_o), .ex_stb_o(ex_stb_o)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model state
  int                 m_phase;
  logic [PC_W-1:0]    m_pc, m_fa;
  logic [INSTR_W-1:0] m_ir;
  logic               m_val;
  logic               m_after_flush;
  int                 m_hold;
  string              pc_tag, ph_tag, ir_tag, ex_tag;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check(ph_tag, "phase", 32'(phase_o), 32'(m_phase));
    check(pc_tag, "pc", 32'(pc_o), 32'(m_pc));
    check(pc_tag, "fetch_addr", 32'(fetch_addr_o), 32'(m_fa));
    check(ir_tag, "ir", 32'(ir_o), 32'(m_ir));
    check(ex_tag, "ex_valid", 32'(ex_valid_o), 32'(m_val));
    check(ex_tag, "strobes", 32'(ex_stb_o), m_val ? (32'd1 << m_phase) : 32'd0);
  endtask

  task automatic model_reset();
    m_phase = 0; m_pc = RST_PC; m_fa = RST_PC; m_ir = '0; m_val = 1'b0;
    m_after_flush = 1'b0;
    pc_tag = "R1"; ph_tag = "R1"; ir_tag = "R1"; ex_tag = "R1";
  endtask

  task automatic model_step(input logic fl, input logic [PC_W-1:0] tgt);
    if (m_hold > 0) begin
      m_hold--;
      if (m_hold == 0) ex_tag = "R5";
      return;
    end
    ph_tag = "R2"; pc_tag = "R3"; ir_tag = "R4";
    if (fl && m_phase != 3) pc_tag = "R9";
    if (m_phase == 0) begin
      m_fa = m_pc;
      m_pc = m_pc + PC_W'(1);
    end else if (m_phase == 3) begin
      m_ir = mem_word(m_fa);
      if (fl) begin
        m_pc = tgt; m_val = 1'b0; m_after_flush = 1'b1;
        pc_tag = "R8"; ex_tag = "R8";
      end else begin
        ex_tag = (!m_val && m_after_flush) ? "R10" : "R6";
        ir_tag = "R7";
        m_val = 1'b1; m_after_flush = 1'b0;
      end
    end
    m_phase = (m_phase + 1) % 4;
  endtask

  // called at a falling edge
  task automatic cycle(input logic fl, input logic [PC_W-1:0] tgt);
    flush_req = fl;
    flush_target = tgt;
    @(posedge clk);
    model_step(fl, tgt);
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    flush_req = 1'b0;
    model_reset();
    #1;
    compare_all();          // R1: asynchronous, no edge needed
    @(negedge clk);
    compare_all();
    rst_n = 1'b1;
    m_hold = 2;
  endtask

  task automatic run_to_phase(input int ph);
    while (m_phase != ph || m_hold > 0) cycle(1'b0, '0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    m_hold = 0;
    repeat (2) @(negedge clk);
    do_reset();

    // plain run: fetch-only first cycle, then overlapped execution
    repeat (24) cycle(1'b0, '0);

    // requests outside Q4 must be ignored (R9)
    run_to_phase(1);
    cycle(1'b1, 12'h3C0);
    cycle(1'b1, 12'h3C4);
    repeat (4) cycle(1'b0, '0);
    run_to_phase(0);
    cycle(1'b1, 12'h111);

    // redirect in Q4 (R8, R10)
    run_to_phase(3);
    cycle(1'b1, 12'h200);
    repeat (8) cycle(1'b0, '0);

    // back-to-back redirects
    run_to_phase(3);
    cycle(1'b1, 12'h040);
    run_to_phase(3);
    cycle(1'b1, 12'h080);
    repeat (8) cycle(1'b0, '0);

    // redirect to the last address: counter wraps (R3)
    run_to_phase(3);
    cycle(1'b1, 12'hFFF);
    repeat (12) cycle(1'b0, '0);

    // reset in the middle of a run (R1, R5)
    cycle(1'b0, '0);
    do_reset();
    repeat (12) cycle(1'b0, '0);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic fl;
      fl = ($urandom % 6) == 0;
      cycle(fl, PC_W'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule